// File: doc/BRIEF.md
# Eight-Channel Down-Counting Timer Bank

The block is a bank of independent down-counting timers reached through an APB slave port. Every channel holds a reload value, a live count and a small control word. A channel counts only in clock cycles where the shared tick strobe is high. The tick is a single-cycle pulse in the bus clock domain, and it stands in for a slower timer clock.

When an enabled channel is at zero and a tick arrives, the channel rolls over and raises one pending event. In periodic mode the channel then reloads from its reload register. In free-running mode it wraps to all-ones. Software clears a pending event by reading an end-of-interrupt location, either the channel's own location or a shared one that clears every channel.

Each channel drives one interrupt line. The line is the pending bit gated by the channel's mask bit. Shared status words report the raw and the gated pending bits of all channels, and a constant identification word can be read.

Top module: `apb_countdown_bank`

## Requirements
- R1: Channel n occupies addresses 20*n to 20*n+19. Within a channel, the offsets are: reload 0x00, live count 0x04, control 0x08, end-of-interrupt 0x0C, gated status 0x10. The shared words are: gated status 0xA0, shared end-of-interrupt 0xA4, raw status 0xA8, and the identification word 0xAC, which reads 0x54430100. Every other address reads zero. Writes go only to the reload and control words; a write anywhere else changes nothing.
- R2: After a synchronous reset, held low for at least one clock, every reload, count, control and pending bit reads zero and every interrupt line is low.
- R3: In periodic mode (control bit 1 = 1), an enabled channel that takes a tick while at zero reloads its count from the reload register. With reload value L, a rollover therefore occurs every L+1 ticks.
- R4: In free-running mode (control bit 1 = 0), an enabled channel that takes a tick while at zero reloads 0xFFFFFFFF.
- R5: While control bit 0 (enable) is 0, the count holds its value on any tick. Writing the reload register never changes the live count directly.
- R6: A control write that sets bit 0 while the channel is disabled copies the reload register into the count at that write's clock edge.
- R7: Every rollover sets the channel's pending bit. Bit n of the raw status word shows channel n's pending bit whether or not the channel is masked.
- R8: A read of a channel's end-of-interrupt location clears that channel's pending bit. A read of 0xA4 clears the pending bits of all channels. Both reads return zero.
- R9: If a rollover and an end-of-interrupt read fall in the same cycle, the pending bit stays set.
- R10: Interrupt line n is high exactly when channel n is pending and control bit 2 (mask) is 0. The channel's 0x10 word and bit n of 0xA0 return the same gated value.
- R11: An enabled channel whose count is nonzero decrements by exactly one on each tick cycle and holds on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid during a read |
| tick | input | 1 | Single-cycle counting strobe |
| irq | output | 8 | Gated interrupt line per channel |

## Verification
Read data is combinational, so it is due in the access-phase cycle of a read. It reflects the state before that cycle's clock edge. A write, an enable edge, a tick-driven decrement or rollover, and an end-of-interrupt clear all take effect at the clock edge that ends the access or tick cycle. The interrupt lines follow in that same cycle, with no further register stage. The bench drives every input just after a falling edge. It compares read data one time unit into the access phase against a reference model that is stepped on rising edges, and it checks the interrupt lines a few time units after each falling edge. The result is that every sample is taken exactly one edge after the event that caused it.

// File: rtl/cdt_pkg.sv
// Package: shared constants and types of the down-counting timer bank.
// Assumes byte addresses; offsets are relative to a channel base or to the
// shared register base.
package cdt_pkg;
    localparam int OFF_RELOAD = 0;
    localparam int OFF_COUNT  = 4;
    localparam int OFF_CTRL   = 8;
    localparam int OFF_ACK    = 12;
    localparam int OFF_GSTAT  = 16;

    localparam int SH_GSTAT   = 0;
    localparam int SH_ACKALL  = 4;
    localparam int SH_RAW     = 8;
    localparam int SH_IDENT   = 12;
    localparam int SH_SPAN    = 16;

    // Control word: bit 0 run, bit 1 periodic, bit 2 mask.
    typedef struct packed {
        logic mask;
        logic periodic;
        logic run;
    } chan_ctrl_t;
endpackage

// File: rtl/cdt_decode.sv
// Module: cdt_decode
// Maps a byte address onto a one-hot channel hit plus an in-channel offset,
// or onto the shared register window. Assumes NUM_CH*STRIDE <= SHARED_BASE.
module cdt_decode #(
    parameter int NUM_CH      = 8,
    parameter int ADDR_W      = 8,
    parameter int STRIDE      = 20,
    parameter int SHARED_BASE = 160
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] ch_hit,
    output logic [ADDR_W-1:0] ch_off,
    output logic              sh_hit,
    output logic [ADDR_W-1:0] sh_off
);
    import cdt_pkg::*;

    // Purpose: find which channel window, if any, contains the address.
    always_comb begin
        ch_hit = '0;
        ch_off = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (int'(addr) >= n*STRIDE && int'(addr) < (n+1)*STRIDE) begin
                ch_hit[n] = 1'b1;
                ch_off    = addr - ADDR_W'(n*STRIDE);
            end
        end
    end

    // Purpose: flag the shared window and its relative offset.
    always_comb begin
        sh_hit = (int'(addr) >= SHARED_BASE) && (int'(addr) < SHARED_BASE + SH_SPAN);
        sh_off = addr - ADDR_W'(SHARED_BASE);
    end
endmodule

// File: rtl/cdt_channel.sv
// Module: cdt_channel
// One down-counting channel: reload register, live count, control word and
// a pending flag. Assumes at most one bus strobe per cycle and that tick is
// a single-cycle pulse in the clk domain.
module cdt_channel #(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               reload_we,
    input  logic               ctrl_we,
    input  logic [CNT_W-1:0]   wdata,
    input  logic [2:0]         ctrl_wdata,
    input  logic               ack_rd,
    output logic [CNT_W-1:0]   reload_q,
    output logic [CNT_W-1:0]   count_q,
    output cdt_pkg::chan_ctrl_t ctrl_q,
    output logic               pend_q,
    output logic               irq
);
    import cdt_pkg::*;

    logic wrap;
    logic start;

    // Purpose: rollover happens on a tick while enabled and at zero.
    assign wrap  = ctrl_q.run && tick && (count_q == '0);
    // Purpose: a control write that turns a stopped channel on.
    assign start = ctrl_we && ctrl_wdata[0] && !ctrl_q.run;

    // Purpose: reload and control registers, written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            ctrl_q   <= '0;
        end else begin
            if (reload_we) reload_q <= wdata;
            if (ctrl_we)   ctrl_q   <= chan_ctrl_t'(ctrl_wdata);
        end
    end

    // Purpose: live count with start load, rollover reload and decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (start) begin
            count_q <= reload_q;
        end else if (wrap) begin
            count_q <= ctrl_q.periodic ? reload_q : '1;
        end else if (ctrl_q.run && tick) begin
            count_q <= count_q - 1'b1;
        end
    end

    // Purpose: pending flag, set by rollover, cleared by acknowledge read.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (wrap)   pend_q <= 1'b1;
        else if (ack_rd) pend_q <= 1'b0;
    end

    // Purpose: gated interrupt line.
    assign irq = pend_q && !ctrl_q.mask;

    a_r3_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && ctrl_q.periodic) |=> (count_q == $past(reload_q)));
    a_r4_free_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !ctrl_q.periodic) |=> (count_q == '1));
    a_r5_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !start) |=> $stable(count_q));
    a_r6_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (count_q == $past(reload_q)));
    a_r7_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> pend_q);
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !wrap) |=> !pend_q);
    a_r9_wrap_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && wrap) |=> pend_q);
    a_r10_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.mask |-> !irq);
    a_r11_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.run && tick && count_q != '0 && !ctrl_we) |=> (count_q == $past(count_q) - 1'b1));
endmodule

// File: rtl/apb_countdown_bank.sv
// Module: apb_countdown_bank
// APB slave holding NUM_CH down-counting channels plus shared status words.
// Assumes an APB master without wait states (no ready output) and that
// NUM_CH <= CNT_W so that status words fit.
module apb_countdown_bank #(
    parameter int          NUM_CH      = 8,
    parameter int          CNT_W       = 32,
    parameter int          ADDR_W      = 8,
    parameter int          STRIDE      = 20,
    parameter int          SHARED_BASE = 160,
    parameter logic [31:0] IDENT_WORD  = 32'h5443_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [CNT_W-1:0]  pwdata,
    output logic [CNT_W-1:0]  prdata,
    input  logic              tick,
    output logic [NUM_CH-1:0] irq
);
    import cdt_pkg::*;

    logic [NUM_CH-1:0] ch_hit;
    logic [ADDR_W-1:0] ch_off;
    logic              sh_hit;
    logic [ADDR_W-1:0] sh_off;
    logic              wr_acc;
    logic              rd_acc;
    logic              ack_all;

    logic [CNT_W-1:0]  reload_a [NUM_CH];
    logic [CNT_W-1:0]  count_a  [NUM_CH];
    chan_ctrl_t        ctrl_a   [NUM_CH];
    logic [NUM_CH-1:0] pend_v;
    logic [NUM_CH-1:0] gated_v;
    logic [CNT_W-1:0]  rdata;

    cdt_decode #(
        .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .STRIDE(STRIDE), .SHARED_BASE(SHARED_BASE)
    ) u_dec (
        .addr(paddr), .ch_hit(ch_hit), .ch_off(ch_off), .sh_hit(sh_hit), .sh_off(sh_off)
    );

    // Purpose: access-phase strobes for writes, reads and the shared clear.
    assign wr_acc  = psel && penable && pwrite;
    assign rd_acc  = psel && penable && !pwrite;
    assign ack_all = rd_acc && sh_hit && (int'(sh_off) == SH_ACKALL);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic sel_reload, sel_ctrl, sel_ack;
        assign sel_reload = wr_acc && ch_hit[n] && (int'(ch_off) == OFF_RELOAD);
        assign sel_ctrl   = wr_acc && ch_hit[n] && (int'(ch_off) == OFF_CTRL);
        assign sel_ack    = (rd_acc && ch_hit[n] && (int'(ch_off) == OFF_ACK)) || ack_all;

        cdt_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .reload_we(sel_reload), .ctrl_we(sel_ctrl),
            .wdata(pwdata), .ctrl_wdata(pwdata[2:0]), .ack_rd(sel_ack),
            .reload_q(reload_a[n]), .count_q(count_a[n]), .ctrl_q(ctrl_a[n]),
            .pend_q(pend_v[n]), .irq(gated_v[n])
        );
    end

    assign irq = gated_v;

    // Purpose: read multiplexer over channel and shared words.
    always_comb begin
        rdata = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (ch_hit[n]) begin
                if (int'(ch_off) == OFF_RELOAD) rdata = reload_a[n];
                if (int'(ch_off) == OFF_COUNT)  rdata = count_a[n];
                if (int'(ch_off) == OFF_CTRL)   rdata = CNT_W'(ctrl_a[n]);
                if (int'(ch_off) == OFF_GSTAT)  rdata = CNT_W'(gated_v[n]);
            end
        end
        if (sh_hit) begin
            if (int'(sh_off) == SH_GSTAT) rdata = CNT_W'(gated_v);
            if (int'(sh_off) == SH_RAW)   rdata = CNT_W'(pend_v);
            if (int'(sh_off) == SH_IDENT) rdata = CNT_W'(IDENT_WORD);
        end
    end

    // Purpose: drive read data only while a read is selected.
    assign prdata = (psel && !pwrite) ? rdata : '0;

    a_r7_raw_covers_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~pend_v) == '0);
    a_r2_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (irq == '0));
endmodule

// File: tb/apb_countdown_bank_bench.sv
// Bench: reference-model comparison with fixed-seed random traffic and
// directed corner cases for the down-counting timer bank.
module apb_countdown_bank_bench;
    localparam int          NCH   = 8;
    localparam logic [31:0] IDENT = 32'h5443_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        tick = 1'b0;
    logic [7:0]  irq;

    int n_chk = 0, n_fail = 0;
    int tick_pct = 0;
    bit tick_force = 1'b0;

    // Reference model state.
    logic [31:0] m_rel [NCH];
    logic [31:0] m_cnt [NCH];
    logic [2:0]  m_ctl [NCH];
    logic [NCH-1:0] m_pend;

    always #10 clk = ~clk;

    apb_countdown_bank u_apb_countdown_bank (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .tick(tick), .irq(irq)
    );

    function automatic logic [NCH-1:0] m_gated();
        logic [NCH-1:0] g;
        for (int n = 0; n < NCH; n++) g[n] = m_pend[n] & ~m_ctl[n][2];
        return g;
    endfunction

    // Reference model, stepped on rising edges from the driven inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NCH; n++) begin
                m_rel[n] = '0; m_cnt[n] = '0; m_ctl[n] = '0;
            end
            m_pend = '0;
        end else begin
            for (int n = 0; n < NCH; n++) begin
                bit inwin, acc, roll, go, clr;
                inwin = (paddr < 160) && (int'(paddr) / 20 == n);
                acc   = psel && penable;
                roll  = m_ctl[n][0] && tick && (m_cnt[n] == 0);
                go    = acc && pwrite && inwin && (int'(paddr) % 20 == 8) && pwdata[0] && !m_ctl[n][0];
                clr   = acc && !pwrite && ((inwin && int'(paddr) % 20 == 12) || paddr == 8'hA4);
                if (go)                     m_cnt[n] = m_rel[n];
                else if (roll)              m_cnt[n] = m_ctl[n][1] ? m_rel[n] : 32'hFFFF_FFFF;
                else if (m_ctl[n][0] && tick) m_cnt[n] = m_cnt[n] - 1;
                if (roll)      m_pend[n] = 1'b1;
                else if (clr)  m_pend[n] = 1'b0;
                if (acc && pwrite && inwin && int'(paddr) % 20 == 0) m_rel[n] = pwdata;
                if (acc && pwrite && inwin && int'(paddr) % 20 == 8) m_ctl[n] = pwdata[2:0];
            end
        end
    end

    function automatic logic [31:0] exp_rd(logic [7:0] a);
        if (a < 160) begin
            int n = int'(a) / 20;
            int o = int'(a) % 20;
            case (o)
                0:  return m_rel[n];
                4:  return m_cnt[n];
                8:  return {29'd0, m_ctl[n]};
                16: return {31'd0, m_pend[n] & ~m_ctl[n][2]};
                default: return '0;
            endcase
        end
        case (a)
            8'hA0: return {24'd0, m_gated()};
            8'hA8: return {24'd0, m_pend};
            8'hAC: return IDENT;
            default: return '0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        tick = tick_force || (tick_pct > 0 && $urandom_range(99) < tick_pct);
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        cyc(); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        cyc(); penable = 1;
        cyc(); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input string req, output logic [31:0] got);
        logic [31:0] e;
        cyc(); psel = 1; penable = 0; pwrite = 0; paddr = a;
        cyc(); penable = 1;
        #1; got = prdata; e = exp_rd(a);
        chk(got === e, req, got, e);
        cyc(); psel = 0; penable = 0;
    endtask

    task automatic ticks(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); tick = 1;
        end
        @(negedge clk); tick = 0;
    endtask

    // Interrupt lines against the model every cycle (R10).
    always @(negedge clk) begin
        if (rst_n) begin
            #3;
            chk(irq === m_gated(), "R10 irq", {24'd0, irq}, {24'd0, m_gated()});
        end
    end

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        logic [31:0] v, held;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R2: reset state.
        bus_rd(8'h08, "R2 ctrl0", v);       chk(v == 0, "R2 ctrl0 lit", v, 0);
        bus_rd(8'hA8, "R2 raw", v);         chk(v == 0, "R2 raw lit", v, 0);
        chk(irq == 0, "R2 irq", {24'd0, irq}, 0);
        // R1: identification word and an unused address.
        bus_rd(8'hAC, "R1 ident", v);       chk(v == IDENT, "R1 ident lit", v, IDENT);
        bus_rd(8'hB0, "R1 unused", v);      chk(v == 0, "R1 unused lit", v, 0);
        bus_wr(8'h04, 32'h55);              bus_rd(8'h04, "R1 ro count", v);
        chk(v == 0, "R1 ro count lit", v, 0);

        // R6 / R3: channel 0 periodic, reload 3.
        bus_wr(8'h00, 32'd3);
        bus_wr(8'h08, 32'b011);
        bus_rd(8'h04, "R6 start load", v);  chk(v == 3, "R6 lit", v, 3);
        ticks(2);
        bus_rd(8'h04, "R11 step", v);       chk(v == 1, "R11 lit", v, 1);
        ticks(2);
        bus_rd(8'h04, "R3 periodic reload", v); chk(v == 3, "R3 lit", v, 3);
        bus_rd(8'hA8, "R7 raw", v);         chk(v[0] == 1, "R7 lit", v, 1);

        // R4: channel 1 free-running, reload 1.
        bus_wr(8'd20, 32'd1);
        bus_wr(8'd28, 32'b001);
        ticks(2);
        bus_rd(8'd24, "R4 wrap", v);        chk(v == 32'hFFFF_FFFF, "R4 lit", v, 32'hFFFF_FFFF);

        // R10: mask channel 1 while pending.
        bus_wr(8'd28, 32'b101);
        chk(irq[1] == 0, "R10 masked", {31'd0, irq[1]}, 0);
        bus_rd(8'd36, "R10 gstat", v);      chk(v == 0, "R10 gstat lit", v, 0);
        bus_rd(8'hA8, "R7 raw masked", v);  chk(v[1] == 1, "R7 masked lit", v, 2);

        // R9: channel 2 reload 0 rolls on every tick; ack during rollover.
        bus_wr(8'd40, 32'd0);
        bus_wr(8'd48, 32'b011);
        tick_force = 1;
        bus_rd(8'd52, "R9 ack read", v);
        tick_force = 0; @(negedge clk); tick = 0;
        bus_rd(8'hA8, "R9 raw", v);         chk(v[2] == 1, "R9 lit", v, 4);
        bus_rd(8'd52, "R8 ack read", v);    chk(v == 0, "R8 ack data", v, 0);
        bus_rd(8'hA8, "R8 raw", v);         chk(v[2] == 0, "R8 lit", v, 0);

        // R5: stop channel 0, tick, rewrite reload.
        bus_wr(8'h08, 32'b010);
        bus_rd(8'h04, "R5 before", held);
        ticks(5);
        bus_wr(8'h00, 32'd9);
        bus_rd(8'h04, "R5 after", v);       chk(v == held, "R5 lit", v, held);

        // R8: shared acknowledge clears all.
        bus_rd(8'hA4, "R8 ackall", v);
        bus_rd(8'hA8, "R8 all clear", v);   chk(v == 0, "R8 all lit", v, 0);

        // Random traffic compared with the model (R1, R3, R4, R7, R11).
        for (int i = 0; i < 3000; i++) begin
            int ch = $urandom_range(NCH - 1);
            int kind = $urandom_range(9);
            logic [7:0] a;
            tick_pct = (i % 500 < 250) ? 60 : 15;
            if (kind < 2)      bus_wr(8'(ch * 20), ($urandom_range(3) == 0) ? $urandom : 32'($urandom_range(12)));
            else if (kind < 4) bus_wr(8'(ch * 20 + 8), 32'($urandom_range(7)));
            else if (kind < 8) begin
                a = 8'(ch * 20 + 4 * $urandom_range(4));
                bus_rd(a, "R11 random read", v);
            end else begin
                a = 8'(160 + 4 * $urandom_range(3));
                bus_rd(a, "R1 shared read", v);
            end
        end
        tick_pct = 0;
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule